// File: doc/BRIEF.md
# Keypad Dual-Tone Sample Generator

This block produces the digital sample stream for telephone keypad signalling. A 4-bit key code is loaded into a code register, and a separate transmit-enable bit starts and stops the tone. While enabled, the block sums one sinusoid from the low frequency group and one from the high frequency group. The high-group component is about 2 dB louder than the low-group one. The sum is emitted as a signed 14-bit sample. A new sample is produced once every 448 system clocks, which gives about 7.99 kHz from a 3.579545 MHz clock.

The key code is sampled into a working copy only on the cycle where the enable bit goes from 0 to 1. Both phase accumulators restart from phase zero on that cycle. Writes to the code register during a tone are therefore stored for the next tone and leave the current one alone. When the enable bit is 0, the output rests at 0, which is the midscale level. A synchronous power-down input clears the code register, the enable bit and the output.

Top module: `dtmf_tone_gen`

## Requirements
- R1: The 4-bit code selects the (low, high) pair in Hz as follows: 1=(697,1209), 2=(697,1336), 3=(697,1477), 4=(770,1209), 5=(770,1336), 6=(770,1477), 7=(852,1209), 8=(852,1336), 9=(852,1477), 10=(941,1336), 11=(941,1209), 12=(941,1477), 13=(697,1633), 14=(770,1633), 15=(852,1633), 0=(941,1633). Each group's 24-bit phase step is round(f*2^24*448/3579545). This step keeps every tone within 1.5% of its nominal frequency.
- R2: `sample_vld` pulses for one cycle every 448 clocks. A 0-to-1 write of the enable bit restarts this count. The first pulse comes 448 clocks after the enabling edge. Pulse n (n = 0, 1, ...) carries the sample for accumulator phase n*step mod 2^24 in each group. Between pulses, the output does not change while the tone is on.
- R3: Each group's sine value is round(2047*sin(2*pi*(k+0.5)/256)), where k is the top 8 bits of that group's accumulator. The table is quarter-wave symmetric.
- R4: The output equals low + floor(high*161/128), saturated to the 14-bit signed range. This makes the high group about 2 dB louder than the low group.
- R5: A code written while the enable bit is 1 does not change the tone being sent. The stored code takes effect at the next 0-to-1 write of the enable bit.
- R6: While the enable bit is 0, `sample_o` is 0. It becomes 0 on the clock edge that writes the enable bit to 0.
- R7: Asserting `pdn_i` on a clock edge clears the code register to 0000 and the enable bit to 0, and forces the output to 0. Enabling again without a new code write sends the code 0000 pair (941/1633).
- R8: After reset, `sample_o` is 0 and stays 0 until a tone is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, sampled on the clock |
| pdn_i | input | 1 | Synchronous power-down; clears code, enable and output |
| code_we_i | input | 1 | Write strobe for the code register |
| code_i | input | 4 | Key code to store |
| tx_we_i | input | 1 | Write strobe for the transmit-enable bit |
| tx_en_i | input | 1 | Value written to the transmit-enable bit |
| sample_o | output | 14 | Signed summed sample |
| sample_vld_o | output | 1 | One-cycle pulse marking each new sample slot |

## Verification
Some properties are checked by assertions on every cycle:
- the working code never changes while the tone is on;
- the output is 0 whenever the enable bit is 0;
- the output holds between sample pulses;
- power-down leaves the code and enable cleared;
- a restart zeroes both accumulators;
- the divider count stays in range.

Other properties can only be shown by the bench's scenarios. These are the actual sample values for all sixteen codes, the 2 dB weighting, the deferred effect of a code written during a tone, and the tone sent after power-down.

// File: rtl/dtmf_gen_pkg.sv
package dtmf_gen_pkg;

    localparam int KEY_W = 4;

    // low-group frequency for a key code, Hz
    function automatic int low_hz(input logic [KEY_W-1:0] key);
        case (key)
            4'd1, 4'd2, 4'd3, 4'd13:   return 697;
            4'd4, 4'd5, 4'd6, 4'd14:   return 770;
            4'd7, 4'd8, 4'd9, 4'd15:   return 852;
            default:                   return 941;
        endcase
    endfunction

    // high-group frequency for a key code, Hz
    function automatic int high_hz(input logic [KEY_W-1:0] key);
        case (key)
            4'd1, 4'd4, 4'd7, 4'd11:   return 1209;
            4'd2, 4'd5, 4'd8, 4'd10:   return 1336;
            4'd3, 4'd6, 4'd9, 4'd12:   return 1477;
            default:                   return 1633;
        endcase
    endfunction

    // rounded phase step for a tone at the divided sample rate
    function automatic longint phase_step(input int hz, input longint clk_hz,
                                          input int div, input int acc_w);
        longint num;
        num = (longint'(hz) <<< acc_w) * longint'(div);
        return (num + clk_hz / 2) / clk_hz;
    endfunction

endpackage

// File: rtl/dtmf_strobe_div.sv
module dtmf_strobe_div #(
    parameter int DIV = 448
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic strobe_o
);
    localparam int CNT_W = $clog2(DIV);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)              cnt_d = '0;
        else if (cnt_q == LAST) cnt_d = '0;
        else                    cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign strobe_o = (cnt_q == LAST);

    // R2
    div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/dtmf_phase_osc.sv
module dtmf_phase_osc #(
    parameter int ACC_W = 24,
    parameter int IDX_W = 8,
    parameter int AMP_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr_i,
    input  logic                    step_i,
    input  logic [ACC_W-1:0]        inc_i,
    output logic signed [AMP_W-1:0] sine_o
);
    localparam int QTR   = 2 ** (IDX_W - 2);
    localparam int MAG_W = AMP_W - 1;
    localparam real PEAK = real'((2 ** MAG_W) - 1);

    typedef logic [MAG_W-1:0] qtab_t [QTR];

    // quarter-wave magnitudes at mid-cell phase, built by series expansion
    function automatic qtab_t make_qtab();
        qtab_t t;
        for (int i = 0; i < QTR; i++) begin
            real x, term, s;
            x    = 1.5707963267948966 * (real'(i) + 0.5) / real'(QTR);
            term = x;
            s    = x;
            for (int k = 1; k < 8; k++) begin
                term = -term * x * x / real'((2 * k) * (2 * k + 1));
                s    = s + term;
            end
            t[i] = MAG_W'($rtoi(PEAK * s + 0.5));
        end
        return t;
    endfunction

    localparam qtab_t QTAB = make_qtab();

    logic [ACC_W-1:0] acc_d, acc_q;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-3:0] addr;
    logic [MAG_W-1:0] mag;

    always_comb begin
        acc_d = acc_q;
        if (clr_i)       acc_d = '0;
        else if (step_i) acc_d = acc_q + inc_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    always_comb begin
        idx  = acc_q[ACC_W-1 -: IDX_W];
        addr = idx[IDX_W-2] ? ~idx[IDX_W-3:0] : idx[IDX_W-3:0];
        mag  = QTAB[addr];
        if (idx[IDX_W-1]) sine_o = -$signed({1'b0, mag});
        else              sine_o =  $signed({1'b0, mag});
    end

    // R2
    osc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (acc_q == '0));

endmodule

// File: rtl/dtmf_tone_gen.sv
module dtmf_tone_gen
    import dtmf_gen_pkg::*;
#(
    parameter int CLK_HZ     = 3579545,
    parameter int SAMPLE_DIV = 448,
    parameter int ACC_W      = 24,
    parameter int IDX_W      = 8,
    parameter int AMP_W      = 12,
    parameter int OUT_W      = 14,
    parameter int HI_GAIN    = 161,
    parameter int GAIN_SHIFT = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pdn_i,
    input  logic                    code_we_i,
    input  logic [3:0]              code_i,
    input  logic                    tx_we_i,
    input  logic                    tx_en_i,
    output logic signed [OUT_W-1:0] sample_o,
    output logic                    sample_vld_o
);
    localparam int NKEY  = 2 ** KEY_W;
    localparam int MUL_W = AMP_W + GAIN_SHIFT + 3;
    localparam logic signed [MUL_W-1:0] GAIN_S = MUL_W'(HI_GAIN);
    localparam logic signed [MUL_W-1:0] MAXV   = MUL_W'((1 <<< (OUT_W - 1)) - 1);
    localparam logic signed [MUL_W-1:0] MINV   = -MAXV - MUL_W'(1);

    typedef logic [ACC_W-1:0] inc_tab_t [NKEY];

    function automatic inc_tab_t build_inc(input bit high);
        inc_tab_t t;
        for (int c = 0; c < NKEY; c++) begin
            int hz;
            hz   = high ? high_hz(KEY_W'(c)) : low_hz(KEY_W'(c));
            t[c] = ACC_W'(phase_step(hz, longint'(CLK_HZ), SAMPLE_DIV, ACC_W));
        end
        return t;
    endfunction

    localparam inc_tab_t INC_LO = build_inc(1'b0);
    localparam inc_tab_t INC_HI = build_inc(1'b1);

    typedef struct packed {
        logic [KEY_W-1:0]        key;
        logic                    en;
        logic [KEY_W-1:0]        live;
        logic signed [OUT_W-1:0] out;
        logic                    vld;
    } gen_st_t;

    gen_st_t st_d, st_q;

    logic                    strobe, restart, rise;
    logic signed [AMP_W-1:0] lo_sine, hi_sine;
    logic signed [MUL_W-1:0] hi_mul, hi_scaled, mix;
    logic signed [OUT_W-1:0] mix_sat;

    assign rise    = tx_we_i && tx_en_i && !st_q.en && !pdn_i;
    assign restart = rise || pdn_i;

    dtmf_strobe_div #(.DIV(SAMPLE_DIV)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (restart),
        .strobe_o(strobe)
    );

    dtmf_phase_osc #(.ACC_W(ACC_W), .IDX_W(IDX_W), .AMP_W(AMP_W)) u_osc_lo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (restart),
        .step_i(strobe && st_q.en),
        .inc_i (INC_LO[st_q.live]),
        .sine_o(lo_sine)
    );

    dtmf_phase_osc #(.ACC_W(ACC_W), .IDX_W(IDX_W), .AMP_W(AMP_W)) u_osc_hi (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (restart),
        .step_i(strobe && st_q.en),
        .inc_i (INC_HI[st_q.live]),
        .sine_o(hi_sine)
    );

    always_comb begin
        hi_mul    = MUL_W'(hi_sine) * GAIN_S;
        hi_scaled = hi_mul >>> GAIN_SHIFT;
        mix       = MUL_W'(lo_sine) + hi_scaled;
        if (mix > MAXV)      mix_sat = OUT_W'(MAXV);
        else if (mix < MINV) mix_sat = OUT_W'(MINV);
        else                 mix_sat = OUT_W'(mix);
    end

    always_comb begin
        st_d = st_q;
        if (code_we_i) st_d.key  = code_i;
        if (tx_we_i)   st_d.en   = tx_en_i;
        if (rise)      st_d.live = st_q.key;
        st_d.vld = strobe && !restart;
        if (!st_d.en)                st_d.out = '0;
        else if (strobe && st_q.en)  st_d.out = mix_sat;
        if (pdn_i) begin
            st_d.key  = '0;
            st_d.en   = 1'b0;
            st_d.live = '0;
            st_d.out  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sample_o     = st_q.out;
    assign sample_vld_o = st_q.vld;

    // R5
    frozen_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.en && $past(st_q.en)) |-> $stable(st_q.live));

    // R6
    quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.en |-> (sample_o == '0));

    // R2
    hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.en && $past(st_q.en) && !sample_vld_o) |-> $stable(sample_o));

    // R7
    pdn_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pdn_i) |-> (!st_q.en && st_q.key == '0 && sample_o == '0));

endmodule

// File: tb/dtmf_tone_gen_bench.sv
module dtmf_tone_gen_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pdn = 1'b0;
    logic code_we = 1'b0;
    logic [3:0] code = 4'd0;
    logic tx_we = 1'b0;
    logic tx_en = 1'b0;
    logic signed [13:0] sample;
    logic vld;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dtmf_tone_gen u_dtmf_tone_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .pdn_i       (pdn),
        .code_we_i   (code_we),
        .code_i      (code),
        .tx_we_i     (tx_we),
        .tx_en_i     (tx_en),
        .sample_o    (sample),
        .sample_vld_o(vld)
    );

    // R1 frequency pairs, written from the requirement
    function automatic int f_lo(input int c);
        case (c)
            1, 2, 3, 13:  return 697;
            4, 5, 6, 14:  return 770;
            7, 8, 9, 15:  return 852;
            default:      return 941;
        endcase
    endfunction

    function automatic int f_hi(input int c);
        case (c)
            1, 4, 7, 11:  return 1209;
            2, 5, 8, 10:  return 1336;
            3, 6, 9, 12:  return 1477;
            default:      return 1633;
        endcase
    endfunction

    // R3 ideal sine cell value
    function automatic int sine12(input int k);
        real v;
        v = 2047.0 * $sin(6.283185307179586 * (real'(k) + 0.5) / 256.0);
        if (v >= 0.0) return $rtoi(v + 0.5);
        else          return -$rtoi(-v + 0.5);
    endfunction

    // R2/R4 expected sample n for a tone pair
    function automatic int expect_sample(input int lf, input int hf, input int n);
        longint il, ih, pl, ph;
        int xl, xh, s;
        il = ((longint'(lf) <<< 24) * 448 + 3579545 / 2) / 3579545;
        ih = ((longint'(hf) <<< 24) * 448 + 3579545 / 2) / 3579545;
        pl = (il * n) & 64'hFFFFFF;
        ph = (ih * n) & 64'hFFFFFF;
        xl = sine12(int'(pl >>> 16));
        xh = sine12(int'(ph >>> 16));
        s  = xl + ((xh * 161) >>> 7);
        if (s > 8191)  s = 8191;
        if (s < -8192) s = -8192;
        return s;
    endfunction

    task automatic check_val(input string req, input int got, input int exp, input int tol);
        int d;
        total++;
        d = got - exp;
        if (d < 0) d = -d;
        if (d > tol) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic write_code(input int c);
        @(negedge clk);
        code_we = 1'b1;
        code = 4'(c);
        @(negedge clk);
        code_we = 1'b0;
    endtask

    task automatic set_en(input bit v);
        @(negedge clk);
        tx_we = 1'b1;
        tx_en = v;
        @(negedge clk);
        tx_we = 1'b0;
    endtask

    // checks samples first_n .. first_n+cnt-1, also the 448-clock spacing
    task automatic run_tone(input string req, input int c, input int first_n, input int cnt);
        int n = first_n;
        int gap = 0;
        int last_gap = -1;
        while (n < first_n + cnt) begin
            @(negedge clk);
            gap++;
            if (vld) begin
                check_val(req, int'(sample), expect_sample(f_lo(c), f_hi(c), n), 3);
                if (last_gap >= 0 || n == 0)
                    check_val("R2 spacing", gap, (n == 0 && first_n == 0) ? 448 : 448, 0);
                last_gap = gap;
                gap = 0;
                n++;
            end
        end
    endtask

    task automatic quiet_window(input string req, input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (i % 64 == 0 || vld) check_val(req, int'(sample), 0, 0);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R8 reset state and quiet idle
        @(negedge clk);
        check_val("R8 reset vld", int'(vld), 0, 0);
        quiet_window("R8 idle output", 600);

        // R1 R3 R4 sweep over all codes, first sample exactly 448 clocks after enable (R2)
        for (int c = 0; c < 16; c++) begin
            write_code(c);
            set_en(1'b1);
            run_tone("R1 code sweep", c, 0, 7);
            set_en(1'b0);
            // R6 output back at midscale on the disabling edge
            check_val("R6 off edge", int'(sample), 0, 0);
        end

        // R6 idle window while disabled
        quiet_window("R6 disabled output", 1200);

        // R5 code written mid-tone does not change the tone
        write_code(5);
        set_en(1'b1);
        run_tone("R5 before write", 5, 0, 3);
        write_code(9);
        run_tone("R5 after write", 5, 3, 4);
        set_en(1'b0);
        set_en(1'b1);
        run_tone("R5 next tone uses new code", 9, 0, 3);

        // R7 power-down during a tone
        write_code(6);
        set_en(1'b0);
        set_en(1'b1);
        run_tone("R7 pre", 6, 0, 2);
        @(negedge clk);
        pdn = 1'b1;
        @(negedge clk);
        pdn = 1'b0;
        check_val("R7 output cleared", int'(sample), 0, 0);
        quiet_window("R7 enable cleared", 900);
        set_en(1'b1);
        run_tone("R7 code cleared to 0000", 0, 0, 4);
        set_en(1'b0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 190000; i++) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule